// File: doc/BRIEF.md
# SDRAM Write Burst Column Engine

This block is the write-burst sequencer on the device side of a single-data-rate synchronous DRAM. It takes commands that have already been decoded: WRITE, READ, PRECHARGE and BURST TERMINATE, each with a bank and an address. From them it produces, in every cycle, a per-byte write strobe, a bank select, a column address and the write data for the memory array. The array latches them on the next rising edge. Because the outputs are combinational from the inputs of the current cycle, the word presented together with a WRITE command lands in the array on the same edge that registers the command.

Bursts are either fixed at 1, 2, 4 or 8 words or run for a full page. A fixed-length burst steps through the columns in order and wraps inside its aligned block. A full-page burst wraps from the last column to column 0 and keeps going until another command stops it. Any later WRITE, READ, BURST TERMINATE or same-bank PRECHARGE ends the running burst, each by its own rule. A byte-mask input removes single byte lanes. The auto-precharge request taken with the WRITE is reported on a one-cycle completion pulse, together with the bank, when a fixed-length burst finishes.

Top module: `sdram_wr_burst`

## Requirements
- R1: In a cycle where a WRITE is presented (cmd_valid_i=1, cmd_i=0), the outputs write the data on dq_i at bank ba_i and at the column addr_i[COL_W-1:0].
- R2: bl_i is sampled with the WRITE. Codes 0, 1, 2 and 3 select 1, 2, 4 and 8 words. The word of the k-th cycle after the command goes to column (start & ~(L-1)) | ((start+k) mod L), where L is the burst length. Once the last word is written, no strobes are asserted until the next WRITE, whatever data is presented.
- R3: bl_i codes 4 to 7 select a full-page burst. The column steps by one in every cycle, wraps from PAGE-1 to 0 and keeps going until the burst is truncated. PAGE is 1024 for the 16-bit organisation.
- R4: A WRITE is accepted in any cycle, including the cycle right after another WRITE. It ends the previous burst, and the word presented with it goes to the new command's own bank and column.
- R5: A READ (cmd_i=1) asserts no strobe in its own cycle and ends the write burst, so no later word of that burst is written.
- R6: A BURST TERMINATE (cmd_i=3) asserts no strobe in its own cycle and ends the burst. The last word written is the one from the previous cycle.
- R7: A PRECHARGE (cmd_i=2) whose ba_i matches the bank of the running burst ends the burst and writes nothing in its own cycle. A PRECHARGE to any other bank leaves the burst running.
- R8: Strobe bit b is asserted only while a word is being written and only when dqm_i[b] is 0. Each mask bit covers byte lane b of the word in that same cycle.
- R9: done_o pulses for one cycle, together with the last word of a fixed-length burst. It carries the burst's bank on done_bank_o and addr_i[10] from the WRITE on done_ap_o. A truncated burst or a full-page burst raises no pulse.
- R10: The column takes addr_i[9:0] in the 16-bit organisation and addr_i[8:0] in the 32-bit one. The bits above the column field, other than bit 10, have no effect.
- R11: During and after reset, and in idle cycles with no burst running, no strobe and no done pulse are asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is presented this cycle |
| cmd_i | input | 2 | 0 write, 1 read, 2 precharge, 3 burst terminate |
| addr_i | input | ADDR_W | Column field in the low bits, auto-precharge request in bit 10 |
| ba_i | input | BANK_W | Bank address |
| bl_i | input | 3 | Burst length code, sampled with WRITE |
| dq_i | input | DATA_W | Write data |
| dqm_i | input | DATA_W/8 | Byte mask, 1 drops the lane |
| wr_en_o | output | DATA_W/8 | Per-byte array write strobe |
| wr_bank_o | output | BANK_W | Array bank select |
| wr_col_o | output | COL_W | Array column address |
| wr_data_o | output | DATA_W | Array write data |
| done_o | output | 1 | Last word of a fixed-length burst |
| done_bank_o | output | BANK_W | Bank of the completing burst |
| done_ap_o | output | 1 | Auto-precharge request of the completing burst |

## Verification
A burst can end and a new command can arrive in the same cycle. The bench provokes the meeting points on purpose: a WRITE issued while another burst is still running, a PRECHARGE to a foreign bank sent into the middle of a burst, and a full-page burst carried across the column wrap and then terminated. A reference model in the bench predicts every cycle's strobe, bank, column and done pulse from the requirements. The monitor then checks whether the new command or the old burst owned that cycle's write.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
  typedef enum logic [1:0] {
    CMD_WRITE = 2'd0,
    CMD_READ  = 2'd1,
    CMD_PRE   = 2'd2,
    CMD_BTERM = 2'd3
  } cmd_e;

  localparam int unsigned AP_BIT = 10;
  localparam int unsigned BL_W   = 3;
endpackage

// File: rtl/sdram_wr_cmd_dec.sv
module sdram_wr_cmd_dec
  import sdram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 10
) (
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic              act_i,
  input  logic [BANK_W-1:0] act_bank_i,
  output logic              start_o,
  output logic              stop_o,
  output logic [COL_W-1:0]  col_o,
  output logic              ap_o
);
  cmd_e cmd;
  assign cmd     = cmd_e'(cmd_i);
  assign start_o = cmd_valid_i && (cmd == CMD_WRITE);
  // a write also ends the old burst, but start has priority in the sequencer
  always_comb begin
    stop_o = 1'b0;
    if (cmd_valid_i && act_i) begin
      unique case (cmd)
        CMD_READ, CMD_BTERM: stop_o = 1'b1;
        CMD_PRE:             stop_o = (ba_i == act_bank_i);
        default:             stop_o = 1'b0;
      endcase
    end
  end
  assign col_o = addr_i[COL_W-1:0];
  assign ap_o  = addr_i[AP_BIT];
endmodule

// File: rtl/sdram_wr_col_gen.sv
module sdram_wr_col_gen
  import sdram_wr_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [COL_W-1:0]  col_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ap_i,
  input  logic [BL_W-1:0]   bl_i,
  output logic              act_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [COL_W-1:0]  col_o,
  output logic              last_o,
  output logic              ap_o,
  output logic              single_o
);
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic             full_q;
  logic [COL_W-1:0] mask_d, sum;

  always_comb begin
    if (bl_i[2]) mask_d = '1;
    else         mask_d = COL_W'((1 << bl_i[1:0]) - 1);
  end
  assign single_o = (bl_i == 3'd0);

  assign sum    = base_q + cnt_q;
  assign col_o  = (base_q & ~mask_q) | (sum & mask_q);
  assign last_o = !full_q && (cnt_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o  <= 1'b0;
      bank_o <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ap_o   <= 1'b0;
    end else if (start_i) begin
      act_o  <= !single_o;
      bank_o <= bank_i;
      base_q <= col_i;
      cnt_q  <= COL_W'(1);
      mask_q <= mask_d;
      full_q <= bl_i[2];
      ap_o   <= ap_i;
    end else if (act_o) begin
      if (stop_i || last_o) act_o <= 1'b0;
      else                  cnt_q <= cnt_q + COL_W'(1);
    end
  end
endmodule

// File: rtl/sdram_wr_lane_mask.sv
module sdram_wr_lane_mask #(
  parameter int unsigned NB = 2
) (
  input  logic          go_i,
  input  logic [NB-1:0] dqm_i,
  output logic [NB-1:0] en_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign en_o[b] = go_i && !dqm_i[b];
  end
endmodule

// File: rtl/sdram_wr_burst.sv
module sdram_wr_burst
  import sdram_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned DATA_W = 16,
  parameter bit          X32    = 1'b0,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned COL_W = X32 ? 9 : 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] ba_i,
  input  logic [BL_W-1:0]   bl_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [NB-1:0]     dqm_i,
  output logic [NB-1:0]     wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [COL_W-1:0]  wr_col_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              done_o,
  output logic [BANK_W-1:0] done_bank_o,
  output logic              done_ap_o
);
  logic              start, stop, cmd_ap, act_q, last, ap_q, single, go;
  logic [COL_W-1:0]  cmd_col, seq_col;
  logic [BANK_W-1:0] bank_q;

  sdram_wr_cmd_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_dec (
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .addr_i(addr_i), .ba_i(ba_i),
    .act_i(act_q), .act_bank_i(bank_q),
    .start_o(start), .stop_o(stop), .col_o(cmd_col), .ap_o(cmd_ap)
  );

  sdram_wr_col_gen #(.BANK_W(BANK_W), .COL_W(COL_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .stop_i(stop),
    .col_i(cmd_col), .bank_i(ba_i), .ap_i(cmd_ap), .bl_i(bl_i),
    .act_o(act_q), .bank_o(bank_q), .col_o(seq_col), .last_o(last),
    .ap_o(ap_q), .single_o(single)
  );

  // new write owns the cycle; otherwise the running burst unless stopped
  assign go = start || (act_q && !stop);

  sdram_wr_lane_mask #(.NB(NB)) u_mask (.go_i(go), .dqm_i(dqm_i), .en_o(wr_en_o));

  assign wr_bank_o   = start ? ba_i : bank_q;
  assign wr_col_o    = start ? cmd_col : seq_col;
  assign wr_data_o   = dq_i;
  assign done_o      = start ? single : (act_q && !stop && last);
  assign done_bank_o = wr_bank_o;
  assign done_ap_o   = start ? cmd_ap : ap_q;
endmodule

// File: rtl/sdram_wr_burst_chk.sv
module sdram_wr_burst_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 10,
  parameter int unsigned NB     = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BANK_W-1:0] ba_i,
  input logic [NB-1:0]     dqm_i,
  input logic [NB-1:0]     wr_en_o,
  input logic [BANK_W-1:0] wr_bank_o,
  input logic [COL_W-1:0]  wr_col_o,
  input logic              done_o,
  input logic              act_q,
  input logic [BANK_W-1:0] bank_q
);
  logic wr_cmd;
  assign wr_cmd = cmd_valid_i && (cmd_i == 2'd0);

  assert_first_word_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmd |-> (wr_col_o == addr_i[COL_W-1:0] && wr_bank_o == ba_i && wr_en_o == ~dqm_i));
  assert_quiet_after_done_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(done_o) && !wr_cmd) |-> (wr_en_o == '0));
  assert_read_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 2'd1) |-> (wr_en_o == '0 && !done_o));
  assert_read_ends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cmd_valid_i && cmd_i == 2'd1) && !wr_cmd) |-> (wr_en_o == '0));
  assert_bterm_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 2'd3) |-> (wr_en_o == '0 && !done_o));
  assert_pre_other_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cmd_valid_i && cmd_i == 2'd2 && ba_i != bank_q) |-> (wr_en_o == ~dqm_i));
  assert_pre_same_bank_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && cmd_valid_i && cmd_i == 2'd2 && ba_i == bank_q) |=> (!act_q));
  assert_lane_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_o & dqm_i) == '0));
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !wr_cmd) |-> (wr_en_o == '0 && !done_o));
endmodule

bind sdram_wr_burst sdram_wr_burst_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .COL_W(COL_W), .NB(NB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .addr_i(addr_i), .ba_i(ba_i), .dqm_i(dqm_i), .wr_en_o(wr_en_o),
  .wr_bank_o(wr_bank_o), .wr_col_o(wr_col_o), .done_o(done_o),
  .act_q(act_q), .bank_q(bank_q)
);

// File: tb/sdram_wr_burst_test.sv
`timescale 1ns/1ps
module sdram_wr_burst_test;
  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int DATA_W = 16;
  localparam int NB     = 2;
  localparam int COL_W  = 10;
  localparam int PAGE   = 1024;

  typedef struct {
    logic [NB-1:0]     en;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] data;
    logic              done;
    logic [BANK_W-1:0] dbank;
    logic              dap;
    string             tag;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic [BANK_W-1:0] ba = '0;
  logic [2:0] bl = '0;
  logic [DATA_W-1:0] dq = '0;
  logic [NB-1:0] dqm = '0;
  logic [NB-1:0] wr_en;
  logic [BANK_W-1:0] wr_bank, done_bank;
  logic [COL_W-1:0] wr_col;
  logic [DATA_W-1:0] wr_data;
  logic done, done_ap;

  int n_chk = 0, n_bad = 0;
  exp_t q[$];

  // reference model state
  bit m_act = 0;
  int m_bank = 0, m_base = 0, m_idx = 0, m_len = 0;
  bit m_ap = 0;

  always #4 clk = ~clk;

  sdram_wr_burst uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_i(addr), .ba_i(ba), .bl_i(bl), .dq_i(dq), .dqm_i(dqm),
    .wr_en_o(wr_en), .wr_bank_o(wr_bank), .wr_col_o(wr_col), .wr_data_o(wr_data),
    .done_o(done), .done_bank_o(done_bank), .done_ap_o(done_ap)
  );

  function automatic logic [ADDR_W-1:0] mk_addr(int col, bit ap, bit [1:0] hi);
    logic [ADDR_W-1:0] a;
    a = ADDR_W'(col);
    a[10] = ap;
    a[12:11] = hi;
    return a;
  endfunction

  function automatic int seq_col(int base, int idx, int len);
    if (len == 0) return (base + idx) % PAGE;
    return (base & ~(len - 1)) | ((base + idx) % len);
  endfunction

  task automatic step(bit v, bit [1:0] c, logic [ADDR_W-1:0] a, int b, bit [2:0] l,
                      logic [DATA_W-1:0] d, logic [NB-1:0] m, string tag);
    exp_t e;
    bit is_wr, stop;
    int len;
    @(posedge clk);
    #1;
    cmd_valid = v; cmd = c; addr = a; ba = BANK_W'(b); bl = l; dq = d; dqm = m;
    is_wr = v && c == 2'd0;
    stop  = v && (c == 2'd1 || c == 2'd3 || (c == 2'd2 && b == m_bank));
    e.en = '0; e.bank = '0; e.col = '0; e.data = d; e.done = 0;
    e.dbank = '0; e.dap = 0; e.tag = tag;
    if (is_wr) begin
      len = l[2] ? 0 : (1 << l[1:0]);
      e.en = ~m; e.bank = BANK_W'(b); e.col = a[COL_W-1:0];
      e.done = (len == 1); e.dbank = BANK_W'(b); e.dap = a[10];
      m_act = (len != 1); m_base = int'(a[COL_W-1:0]); m_idx = 1;
      m_len = len; m_bank = b; m_ap = a[10];
    end else if (m_act && !stop) begin
      e.en = ~m; e.bank = BANK_W'(m_bank);
      e.col = COL_W'(seq_col(m_base, m_idx, m_len));
      e.done = (m_len != 0) && (m_idx == m_len - 1);
      e.dbank = BANK_W'(m_bank); e.dap = m_ap;
      if (e.done) m_act = 0; else m_idx++;
    end else if (m_act && stop) begin
      m_act = 0;
    end
    q.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, 0, 3'd0, DATA_W'(16'hA500 + i), '0, tag);
  endtask

  task automatic data_only(int n, logic [NB-1:0] m, string tag);
    for (int i = 0; i < n; i++) step(0, 2'd0, '0, 0, 3'd0, DATA_W'(16'h1000 * (i + 1) + i), m, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        n_chk++;
        bad = (wr_en !== e.en) || (done !== e.done);
        if (e.en != '0 && (wr_bank !== e.bank || wr_col !== e.col || wr_data !== e.data)) bad = 1;
        if (e.done && (done_bank !== e.dbank || done_ap !== e.dap)) bad = 1;
        if (bad) begin
          n_bad++;
          $display("FAIL %s: got en=%b bank=%0d col=%0d data=%h done=%b/%0d/%b exp en=%b bank=%0d col=%0d data=%h done=%b/%0d/%b",
                   e.tag, wr_en, wr_bank, wr_col, wr_data, done, done_bank, done_ap,
                   e.en, e.bank, e.col, e.data, e.done, e.dbank, e.dap);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: got hang, exp end of run");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R11: reset state observed with data on the bus
    dq = 16'hFFFF;
    #3;
    n_chk++;
    if (wr_en !== '0 || done !== 1'b0) begin
      n_bad++;
      $display("FAIL R11 reset: got en=%b done=%b exp en=00 done=0", wr_en, done);
    end
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    idle(3, "R11 idle");

    // R2/R9: BL4 from col 5 wraps within block 4..7, auto precharge set
    step(1, 2'd0, mk_addr(5, 1, 0), 1, 3'd2, 16'h1111, 2'b00, "R2 bl4 first");
    data_only(3, 2'b00, "R2 bl4 seq R9");
    data_only(2, 2'b00, "R2 after burst ignored");

    // R8: BL8 with varying lane masks
    step(1, 2'd0, mk_addr(16'h3A, 0, 0), 2, 3'd3, 16'h2222, 2'b01, "R8 first masked");
    step(0, 2'd0, '0, 0, 3'd0, 16'h2301, 2'b10, "R8 hi masked");
    step(0, 2'd0, '0, 0, 3'd0, 16'h2302, 2'b11, "R8 both masked");
    data_only(5, 2'b00, "R8 open R2 bl8");
    idle(1, "R2 idle");

    // R4: back-to-back writes, BL1 then BL2 then BL2, different banks
    step(1, 2'd0, mk_addr(7, 1, 0), 0, 3'd0, 16'h3333, 2'b00, "R4 bl1 R9");
    step(1, 2'd0, mk_addr(9, 0, 0), 3, 3'd1, 16'h3434, 2'b00, "R4 bl2 a");
    step(1, 2'd0, mk_addr(16'h20, 1, 0), 3, 3'd1, 16'h3535, 2'b00, "R4 bl2 b");
    data_only(1, 2'b00, "R4 bl2 b second");
    idle(1, "R4 idle");

    // R4: WRITE truncates a running BL8 in another bank
    step(1, 2'd0, mk_addr(16, 0, 0), 1, 3'd3, 16'h4000, 2'b00, "R4 old");
    data_only(1, 2'b00, "R4 old cont");
    step(1, 2'd0, mk_addr(40, 0, 0), 2, 3'd2, 16'h4100, 2'b00, "R4 new");
    data_only(3, 2'b00, "R4 new cont");
    idle(1, "R4 idle2");

    // R5: READ cuts a BL4
    step(1, 2'd0, mk_addr(100, 1, 0), 0, 3'd2, 16'h5000, 2'b00, "R5 start");
    step(1, 2'd1, mk_addr(0, 0, 0), 0, 3'd0, 16'h5001, 2'b00, "R5 read edge");
    data_only(2, 2'b00, "R5 after read");

    // R6: BTERM cuts a BL8
    step(1, 2'd0, mk_addr(0, 0, 0), 3, 3'd3, 16'h6000, 2'b00, "R6 start");
    data_only(1, 2'b00, "R6 cont");
    step(1, 2'd3, '0, 0, 3'd0, 16'h6002, 2'b00, "R6 bterm edge");
    data_only(2, 2'b00, "R6 after");

    // R7: PRECHARGE to another bank keeps the burst; same bank stops it
    step(1, 2'd0, mk_addr(8, 0, 0), 1, 3'd3, 16'h7000, 2'b00, "R7 start");
    step(1, 2'd2, '0, 2, 3'd0, 16'h7001, 2'b00, "R7 other bank");
    data_only(1, 2'b00, "R7 cont");
    step(1, 2'd2, '0, 1, 3'd0, 16'h7003, 2'b00, "R7 same bank");
    data_only(2, 2'b00, "R7 after");

    // R3: full page across the wrap, then BTERM; code 4 also full page, cut by READ
    step(1, 2'd0, mk_addr(1021, 1, 0), 2, 3'd7, 16'h8000, 2'b00, "R3 start");
    data_only(6, 2'b00, "R3 wrap");
    step(1, 2'd3, '0, 0, 3'd0, 16'h8007, 2'b00, "R3 bterm");
    step(1, 2'd0, mk_addr(1022, 0, 0), 0, 3'd4, 16'h8100, 2'b00, "R3 code4");
    data_only(9, 2'b00, "R3 code4 run");
    step(1, 2'd1, '0, 0, 3'd0, 16'h8110, 2'b00, "R3 read");
    idle(1, "R3 idle");

    // R10: upper address bits do not move the column
    step(1, 2'd0, mk_addr(16'h2AB, 0, 2'b11), 2, 3'd0, 16'h9000, 2'b00, "R10 hi bits");
    step(1, 2'd0, mk_addr(16'h155, 1, 2'b10), 1, 3'd1, 16'h9100, 2'b00, "R10 hi bits bl2");
    data_only(1, 2'b00, "R10 bl2 second");
    idle(3, "R11 tail");

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule